// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer

This block counts down a programmable timeout and raises an interrupt when the count runs out. Software writes an 8-bit timeout count and chooses whether each count step lasts one second or one minute. A free-running one-second tick from outside drives the count. Three kinds of system activity can each restart the count when enabled: an I/O access to the game-port address, a keyboard interrupt pulse and a mouse interrupt pulse. The block receives the game-port access as a strobe whose address compare has already been made.

On expiry the block sets a sticky status flag. It also drives one line of a 16-bit interrupt request vector, chosen by a 4-bit code in the configuration byte. The control lives in a three-state machine. IDLE means the timeout count is zero and nothing counts. RUN means the block is counting down. EXPIRED means the flag is set and the chosen line is asserted. The transitions are:
- start: IDLE to RUN, on a nonzero count write.
- stop: RUN or EXPIRED to IDLE, on a zero count write.
- reload: RUN to RUN, on an enabled event or a nonzero count write.
- timeout: RUN to EXPIRED, when the last unit elapses with no reload pending.
- rearm: EXPIRED to RUN, on a status clear or a nonzero count write.

Register map, selected by `reg_addr`:
- 0: units. Bit 7 set selects seconds, and clear selects minutes.
- 1: timeout count.
- 2: configuration.
- 3: status. Bit 0 reads the flag, and writing 1 to it clears the flag.

Top module: `evt_wdog`

## Requirements
- R1: After reset, every register reads 0x00, `expired` is 0 and `irq_vec` is all zeros.
- R2: A timeout count of zero disables the watchdog. Writing zero to address 1 clears `expired` on the next cycle, and no expiry follows for any number of ticks.
- R3: With units bit 7 = 1 (seconds), the block expires on the V-th `tick_sec` pulse after a count V (1..255) is written, and never before it.
- R4: With units bit 7 = 0 (minutes, the reset value), the block expires on the 60·V-th tick after V is written. The prescaler stays below 60.
- R5: Only bit 7 of the units register is stored. Bits 6:0 of address 0 read as zero.
- R6: Configuration bit 0 = 1 makes a `gp_access` pulse reload the count to the written value and clear the prescaler. With bit 0 = 0, the pulse has no effect on the expiry time.
- R7: Configuration bit 1 enables reload by `kbd_irq`, and bit 2 enables reload by `mouse_irq`. When cleared, each bit makes its source ignored. Bit 3 is reserved and reads as zero.
- R8: A reload event in the cycle of the final unit wins. No expiry occurs, and the count restarts at the full value.
- R9: Once set, `expired` stays set through ticks and reload events until a status clear or a count write.
- R10: Writing a byte with bit 0 = 1 to address 3 while expired clears `expired` and `irq_vec` and restarts the full count. Writing bit 0 = 0 does nothing.
- R11: Writing a nonzero count while expired clears `expired` and starts a fresh countdown of that length.
- R12: Configuration bits 7:4 give a code C. While expired, `irq_vec` equals 1<<C for C = 1 and C = 3..15. For C = 0 and C = 2, `irq_vec` stays zero while `expired` is still set. `irq_vec` is never nonzero without `expired`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| tick_sec | input | 1 | One-cycle pulse per second of time base |
| gp_access | input | 1 | Pulse on a read or write to the game-port address |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| irq_vec | output | 16 | One-hot interrupt request lines |
| expired | output | 1 | Sticky expiry flag |

## Verification
Some rules are checked by the assertions on every cycle:
- RUN never holds a zero remaining count.
- The prescaler stays below its divisor.
- A reload in RUN lands exactly the written value.
- The flag holds until a clear or a count write removes it.
- The request vector is one-hot or zero, and only while expired.

Other behaviour shows only in the bench's scenarios, which sweep timeout lengths in both unit modes and step through all sixteen mapping codes:
- the exact tick on which expiry lands;
- the full restart after a reload or a rearm;
- the ignoring of disabled sources;
- the line each mapping code selects.

// File: rtl/evt_wdog_pkg.sv
package evt_wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_EXPIRED
    } wd_state_e;

    localparam logic [1:0] A_UNITS = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_CFG   = 2'd2;
    localparam logic [1:0] A_STAT  = 2'd3;
endpackage

// File: rtl/evt_wdog_regs.sv
module evt_wdog_regs
    import evt_wdog_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              expired,
    output logic [7:0]        rdata,
    output logic              sec_mode,
    output logic [CNT_W-1:0]  count_val,
    output logic [2:0]        src_en,
    output logic [CODE_W-1:0] irq_code,
    output logic              count_wr,
    output logic              clr_wr
);
    assign count_wr = we && (addr == A_COUNT);
    assign clr_wr   = we && (addr == A_STAT) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_mode  <= 1'b0;
            count_val <= '0;
            src_en    <= '0;
            irq_code  <= '0;
        end else if (we) begin
            unique case (addr)
                A_UNITS: sec_mode  <= wdata[7];
                A_COUNT: count_val <= wdata[CNT_W-1:0];
                A_CFG: begin
                    src_en   <= wdata[2:0];
                    irq_code <= wdata[7:8-CODE_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_UNITS: rdata[7] = sec_mode;
            A_COUNT: rdata[CNT_W-1:0] = count_val;
            A_CFG:   rdata = {irq_code, 1'b0, src_en};
            A_STAT:  rdata[0] = expired;
            default: rdata = '0;
        endcase
    end

    // R5: the unit bit follows bit 7 of a write to the units register
    p_units_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_UNITS) |=> (sec_mode == $past(wdata[7])));
endmodule

// File: rtl/evt_wdog_core.sv
module evt_wdog_core
    import evt_wdog_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_DIV = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sec_mode,
    input  logic             reload,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam int PRE_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MIN_DIV - 1);

    wd_state_e        state, state_d;
    logic [CNT_W-1:0] remain;
    logic [PRE_W-1:0] presc;
    logic             unit_done;

    assign unit_done = tick && (sec_mode || presc == PRE_LAST);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (count_wr && wr_data != '0) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (count_wr)
                    state_d = (wr_data == '0) ? ST_IDLE : ST_RUN;
                else if (!reload && unit_done && remain == CNT_W'(1))
                    state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (count_wr)
                    state_d = (wr_data == '0) ? ST_IDLE : ST_RUN;
                else if (clr_wr)
                    state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            presc  <= '0;
        end else if (count_wr) begin
            remain <= wr_data;
            presc  <= '0;
        end else if (state == ST_EXPIRED && clr_wr) begin
            remain <= load_val;
            presc  <= '0;
        end else if (state == ST_RUN) begin
            if (reload) begin
                remain <= load_val;
                presc  <= '0;
            end else if (unit_done) begin
                presc <= '0;
                if (remain != CNT_W'(1)) remain <= remain - CNT_W'(1);
            end else if (tick) begin
                presc <= presc + PRE_W'(1);
            end
        end
    end

    always_comb expired = (state == ST_EXPIRED);

    p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (remain != '0));
    p_presc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, presc} < (PRE_W+1)'(MIN_DIV)));
    p_zero_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && wr_data == '0) |=> (!expired && state == ST_IDLE));
    p_reload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && reload && !count_wr) |=>
        (state == ST_RUN && remain == $past(load_val)));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !count_wr && !clr_wr) |=> expired);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && clr_wr && !count_wr) |=> (!expired && state == ST_RUN));
    p_newval_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && count_wr) |=> !expired);
endmodule

// File: rtl/evt_wdog_irqmap.sv
module evt_wdog_irqmap #(
    parameter int LINES    = 16,
    parameter int CODE_W   = 4,
    parameter int BAD_CODE = 2
) (
    input  logic              expired,
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  irq_vec
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        if (g == 0 || g == BAD_CODE) begin : g_dead
            assign irq_vec[g] = 1'b0;
        end else begin : g_live
            assign irq_vec[g] = expired && (code == CODE_W'(g));
        end
    end

    // R12: at most one request line at a time
    always_comb begin
        p_onehot_r12: assert ($onehot0(irq_vec));
    end
endmodule

// File: rtl/evt_wdog.sv
module evt_wdog #(
    parameter int CNT_W     = 8,
    parameter int MIN_DIV   = 60,
    parameter int IRQ_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 tick_sec,
    input  logic                 gp_access,
    input  logic                 kbd_irq,
    input  logic                 mouse_irq,
    output logic [IRQ_LINES-1:0] irq_vec,
    output logic                 expired
);
    localparam int CODE_W = $clog2(IRQ_LINES);

    logic              sec_mode, count_wr, clr_wr, reload;
    logic [CNT_W-1:0]  count_val;
    logic [2:0]        src_en;
    logic [CODE_W-1:0] irq_code;

    evt_wdog_regs #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .expired(expired), .rdata(reg_rdata),
        .sec_mode(sec_mode), .count_val(count_val), .src_en(src_en),
        .irq_code(irq_code), .count_wr(count_wr), .clr_wr(clr_wr)
    );

    assign reload = (src_en[0] && gp_access) || (src_en[1] && kbd_irq)
                 || (src_en[2] && mouse_irq);

    evt_wdog_core #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_sec), .sec_mode(sec_mode),
        .reload(reload), .count_wr(count_wr),
        .wr_data(reg_wdata[CNT_W-1:0]), .clr_wr(clr_wr),
        .load_val(count_val), .expired(expired)
    );

    evt_wdog_irqmap #(.LINES(IRQ_LINES), .CODE_W(CODE_W), .BAD_CODE(2)) u_map (
        .expired(expired), .code(irq_code), .irq_vec(irq_vec)
    );

    p_irq_needs_exp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_vec) |-> expired);
endmodule

// File: tb/evt_wdog_bench.sv
module evt_wdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        tick_sec = 1'b0, gp_access = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0;
    logic [15:0] irq_vec;
    logic        expired;
    int          nvec = 0, nbad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    evt_wdog u_evt_wdog (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_sec(tick_sec),
        .gp_access(gp_access), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
        .irq_vec(irq_vec), .expired(expired)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_sec = 1'b1;
            @(negedge clk); tick_sec = 1'b0;
        end
        #1;
    endtask

    task automatic pulse_src(input int s, input bit with_tick);
        @(negedge clk);
        tick_sec = with_tick; gp_access = (s == 0); kbd_irq = (s == 1); mouse_irq = (s == 2);
        @(negedge clk);
        tick_sec = 1'b0; gp_access = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int vals_s[6] = '{1, 2, 3, 17, 128, 255};
        int vals_m[3] = '{1, 2, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_chk("R1 reg reset", 2'(a), 8'h00);
        chk("R1 expired reset", expired, 0);
        chk("R1 irq reset", irq_vec, 0);

        // R5 units register
        wr(0, 8'hFF); rd_chk("R5 units readback", 0, 8'h80);
        wr(0, 8'h00); rd_chk("R5 units clear", 0, 8'h00);

        // R3 seconds mode sweep, code 3
        wr(0, 8'h80); wr(2, 8'h30);
        foreach (vals_s[i]) begin
            wr(1, 8'(vals_s[i]));
            tick_n(vals_s[i] - 1); chk("R3 early", expired, 0);
            tick_n(1);             chk("R3 on time", expired, 1);
            chk("R12 irq3", irq_vec, 16'h0008);
            wr(1, 8'h00);          chk("R2 zero clears", expired, 0);
            chk("R2 irq clear", irq_vec, 0);
        end

        // R4 minutes mode sweep
        wr(0, 8'h00);
        foreach (vals_m[i]) begin
            wr(1, 8'(vals_m[i]));
            tick_n(60 * vals_m[i] - 1); chk("R4 early", expired, 0);
            tick_n(1);                  chk("R4 on time", expired, 1);
            wr(1, 8'h00);
        end

        // R2 zero count stays disabled
        tick_n(300); chk("R2 disabled", expired, 0);
        rd_chk("R2 count zero", 1, 8'h00);

        // R6, R7 reload sources, seconds mode
        wr(0, 8'h80);
        for (int s = 0; s < 3; s++) begin
            wr(2, 8'h30 | 8'(1 << s));
            wr(1, 8'd5); tick_n(4); pulse_src(s, 1'b0);
            tick_n(4); chk(s == 0 ? "R6 gp reload" : "R7 kbd/mouse reload", expired, 0);
            tick_n(1); chk(s == 0 ? "R6 gp after" : "R7 kbd/mouse after", expired, 1);
            wr(2, 8'h37 & ~8'(1 << s));
            wr(1, 8'd5); tick_n(4); pulse_src(s, 1'b0);
            tick_n(1); chk(s == 0 ? "R6 gp ignored" : "R7 src ignored", expired, 1);
        end
        wr(2, 8'hFF); rd_chk("R7 bit3 reserved", 2, 8'hF7);

        // R8 reload in the final-unit cycle
        wr(2, 8'h32);
        wr(1, 8'd3); tick_n(2); pulse_src(1, 1'b1);
        chk("R8 no expiry", expired, 0);
        tick_n(2); chk("R8 full restart", expired, 0);
        tick_n(1); chk("R8 later expiry", expired, 1);

        // R9 sticky, R10 clear
        tick_n(10); chk("R9 sticky ticks", expired, 1);
        pulse_src(1, 1'b0); chk("R9 sticky reload", expired, 1);
        wr(3, 8'h00); chk("R10 bit0 zero", expired, 1);
        rd_chk("R10 status read", 3, 8'h01);
        wr(3, 8'h01); chk("R10 cleared", expired, 0);
        chk("R10 irq cleared", irq_vec, 0);
        tick_n(2); chk("R10 rearm early", expired, 0);
        tick_n(1); chk("R10 rearm expiry", expired, 1);

        // R11 new count while expired
        wr(1, 8'd4); chk("R11 cleared", expired, 0);
        tick_n(3); chk("R11 early", expired, 0);
        tick_n(1); chk("R11 expiry", expired, 1);
        wr(1, 8'd0); chk("R2 stop", expired, 0);

        // R12 mapping sweep
        for (int c = 0; c < 16; c++) begin
            wr(2, 8'(c << 4)); rd_chk("R12 cfg readback", 2, 8'(c << 4));
            wr(1, 8'd1); tick_n(1);
            chk("R12 flag", expired, 1);
            chk("R12 line", irq_vec, (c == 0 || c == 2) ? 32'd0 : 32'(1 << c));
        end

        done = 1'b1;
        summary();
    end
endmodule